// File: doc/BRIEF.md
# Branch Exception Information Byte Generator

This block sits beside the branch address encoder of an instruction trace unit. For each traced branch it decides which of three optional trailing bytes the branch packet must carry, and it formats those bytes. The bytes describe the exception taken, cancellation of the last traced instruction, pause and resume of an interruptible instruction, and the processor's security, hypervisor and alternate instruction set state after the branch.

State bits (non-secure, hypervisor, alternate instruction set) cost no bytes while they match the values last broadcast. A change in any of them forces the leading info byte out. The exception number and the resume code force bytes by their value. Exception numbers above 15 need a second byte for the upper bits. A hypervisor change also needs the second byte, because that is where the hypervisor bit is carried. A non-zero resume code needs the third byte.

An instruction-only mode folds pause and restart into plain cancellation. In that mode the third byte is never produced. The block reports the byte count and a flag that the address encoder uses to choose its packet form. The bytes come out compacted, leading byte first.

Top module: `xinfo_gen`

## Requirements
- R1: The leading byte (L) is present when alternate set, non-secure or hypervisor differs from its last-broadcast value, or the exception number is non-zero, or the effective resume code is non-zero, or the effective cancel is 1.
- R2: The extension byte (X) is present when exception bits [8:4] are non-zero or the hypervisor bit differs from its last-broadcast value.
- R3: The resume byte (P) is present when the effective resume code is non-zero.
- R4: `byte_cnt` equals the number of bytes present (0 to 3), and `need_info` is 1 exactly when `byte_cnt` is non-zero.
- R5: L is {bit7 = more bytes follow, bit6 = alternate set, bit5 = effective cancel, bits4:1 = exception[3:0], bit0 = non-secure}.
- R6: X is {bit7 = P follows, bit6 = 0, bit5 = hypervisor, bits4:0 = exception[8:4]}.
- R7: P is {bit7 = 0, bit6 = 1, bits5:4 = 0, bits3:0 = effective resume code}, so a final byte is told apart as X or P by bit 6.
- R8: `info_bytes[7:0]` holds L. Bits [15:8] hold X if present, else P if present. Bits [23:16] hold P when both X and P are present. Every unused slot is zero.
- R9: With `instr_only` = 1, the effective resume code is 0, and the effective cancel is the input cancel OR (input resume code non-zero). P is never emitted.
- R10: Results of an input presented with `in_vld` = 1 appear on the outputs one clock later with `out_vld` = 1. In a cycle after one without `in_vld`, `out_vld` is 0 and the other outputs hold their values.
- R11: After reset, `out_vld`, `need_info`, `byte_cnt` and `info_bytes` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Branch information valid this cycle |
| instr_only | input | 1 | Instruction-only trace mode |
| exc_num | input | 9 | Exception number, 0 = none |
| cancel_in | input | 1 | Last traced instruction cancelled |
| resume_code | input | 4 | Pause/resume code, 0 = none |
| nonsec_in | input | 1 | Non-secure state after the branch |
| alt_iset_in | input | 1 | Alternate instruction set after the branch |
| hypmode_in | input | 1 | Hypervisor mode after the branch |
| last_nonsec | input | 1 | Last-broadcast non-secure value |
| last_alt_iset | input | 1 | Last-broadcast alternate set value |
| last_hypmode | input | 1 | Last-broadcast hypervisor value |
| out_vld | output | 1 | Result valid |
| need_info | output | 1 | Packet needs trailing info bytes |
| byte_cnt | output | 2 | Number of info bytes |
| info_bytes | output | 24 | Compacted info bytes, first byte lowest |

## Verification
Each result is due exactly one clock after the edge that samples `in_vld`. The bench drives a vector on a falling edge, lets one rising edge register it, and samples every output on the next falling edge. It then holds `in_vld` low with scrambled inputs for one more cycle and checks at the following falling edge that the outputs held and `out_vld` dropped. The reset values are sampled on a falling edge while reset is still asserted.

// File: rtl/xinfo_pkg.sv
package xinfo_pkg;
   localparam int unsigned XI_BYTE_W = 8;
   localparam int unsigned XI_SLOTS  = 3;

   typedef struct packed {
      logic alt;
      logic hyp;
      logic ns;
   } xi_state_t;

   typedef struct packed {
      logic p;
      logic x;
      logic l;
   } xi_need_t;
endpackage

// File: rtl/xinfo_fold.sv
module xinfo_fold #(
   parameter int unsigned RES_W = 4
) (
   input  logic             instr_only,
   input  logic             cancel_i,
   input  logic [RES_W-1:0] resume_i,
   output logic             cancel_o,
   output logic [RES_W-1:0] resume_o
);
   always_comb begin
      if (instr_only) begin
         cancel_o = cancel_i | (|resume_i);
         resume_o = '0;
      end else begin
         cancel_o = cancel_i;
         resume_o = resume_i;
      end
   end
endmodule

// File: rtl/xinfo_need.sv
module xinfo_need
   import xinfo_pkg::*;
#(
   parameter int unsigned EXCP_W    = 9,
   parameter int unsigned EXCP_LO_W = 4,
   parameter int unsigned RES_W     = 4
) (
   input  xi_state_t         cur,
   input  xi_state_t         last,
   input  logic [EXCP_W-1:0] excp,
   input  logic              cancel,
   input  logic [RES_W-1:0]  resume,
   output xi_need_t          need,
   output logic [1:0]        cnt
);
   logic [2:0] chg;

   always_comb begin
      chg    = cur ^ last;
      need.p = |resume;
      need.x = (|excp[EXCP_W-1:EXCP_LO_W]) | chg[1];
      need.l = (|chg) | (|excp) | (|resume) | cancel;
      cnt    = {1'b0, need.l} + {1'b0, need.x} + {1'b0, need.p};
   end
endmodule

// File: rtl/xinfo_pack.sv
module xinfo_pack
   import xinfo_pkg::*;
#(
   parameter int unsigned EXCP_W    = 9,
   parameter int unsigned EXCP_LO_W = 4,
   parameter int unsigned RES_W     = 4,
   localparam int unsigned HI_W     = EXCP_W - EXCP_LO_W,
   localparam int unsigned OUT_W    = XI_BYTE_W * XI_SLOTS
) (
   input  xi_need_t          need,
   input  xi_state_t         cur,
   input  logic [EXCP_W-1:0] excp,
   input  logic              cancel,
   input  logic [RES_W-1:0]  resume,
   output logic [OUT_W-1:0]  bytes_o
);
   logic [XI_BYTE_W-1:0] raw [XI_SLOTS];
   logic [XI_BYTE_W-1:0] slot [XI_SLOTS];
   logic [4:0] hi_pad;
   logic [3:0] res_pad;

   always_comb begin
      hi_pad             = '0;
      hi_pad[HI_W-1:0]   = excp[EXCP_W-1:EXCP_LO_W];
      res_pad            = '0;
      res_pad[RES_W-1:0] = resume;
      raw[0] = {need.x | need.p, cur.alt, cancel, excp[EXCP_LO_W-1:0], cur.ns};
      raw[1] = {need.p, 1'b0, cur.hyp, hi_pad};
      raw[2] = {2'b01, 2'b00, res_pad};
   end

   always_comb begin
      slot[0] = need.l ? raw[0] : '0;
      if (need.x)      slot[1] = raw[1];
      else if (need.p) slot[1] = raw[2];
      else             slot[1] = '0;
      slot[2] = (need.x && need.p) ? raw[2] : '0;
   end

   for (genvar s = 0; s < XI_SLOTS; s++) begin : g_slot
      assign bytes_o[s*XI_BYTE_W +: XI_BYTE_W] = slot[s];
   end
endmodule

// File: rtl/xinfo_gen.sv
module xinfo_gen
   import xinfo_pkg::*;
#(
   parameter int unsigned EXCP_W    = 9,
   parameter int unsigned EXCP_LO_W = 4,
   parameter int unsigned RES_W     = 4,
   parameter bit          OUT_REG   = 1'b1,
   localparam int unsigned OUT_W    = XI_BYTE_W * XI_SLOTS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic              instr_only,
   input  logic [EXCP_W-1:0] exc_num,
   input  logic              cancel_in,
   input  logic [RES_W-1:0]  resume_code,
   input  logic              nonsec_in,
   input  logic              alt_iset_in,
   input  logic              hypmode_in,
   input  logic              last_nonsec,
   input  logic              last_alt_iset,
   input  logic              last_hypmode,
   output logic              out_vld,
   output logic              need_info,
   output logic [1:0]        byte_cnt,
   output logic [OUT_W-1:0]  info_bytes
);
   if (EXCP_LO_W != 4) begin : g_bad_lo
      $error("xinfo_gen: low exception field must be 4 bits");
   end
   if (EXCP_W <= EXCP_LO_W || EXCP_W - EXCP_LO_W > 5) begin : g_bad_hi
      $error("xinfo_gen: upper exception field must be 1 to 5 bits");
   end
   if (RES_W < 1 || RES_W > 4) begin : g_bad_res
      $error("xinfo_gen: resume code must be 1 to 4 bits");
   end

   xi_state_t        cur_s, last_s;
   xi_need_t         need;
   logic             cancel_eff;
   logic [RES_W-1:0] resume_eff;
   logic [1:0]       cnt_c;
   logic [OUT_W-1:0] bytes_c;

   assign cur_s  = '{alt: alt_iset_in,   hyp: hypmode_in,   ns: nonsec_in};
   assign last_s = '{alt: last_alt_iset, hyp: last_hypmode, ns: last_nonsec};

   xinfo_fold #(.RES_W(RES_W)) u_fold (
      .instr_only (instr_only),
      .cancel_i   (cancel_in),
      .resume_i   (resume_code),
      .cancel_o   (cancel_eff),
      .resume_o   (resume_eff)
   );

   xinfo_need #(.EXCP_W(EXCP_W), .EXCP_LO_W(EXCP_LO_W), .RES_W(RES_W)) u_need (
      .cur    (cur_s),
      .last   (last_s),
      .excp   (exc_num),
      .cancel (cancel_eff),
      .resume (resume_eff),
      .need   (need),
      .cnt    (cnt_c)
   );

   xinfo_pack #(.EXCP_W(EXCP_W), .EXCP_LO_W(EXCP_LO_W), .RES_W(RES_W)) u_pack (
      .need    (need),
      .cur     (cur_s),
      .excp    (exc_num),
      .cancel  (cancel_eff),
      .resume  (resume_eff),
      .bytes_o (bytes_c)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_vld    <= 1'b0;
            need_info  <= 1'b0;
            byte_cnt   <= '0;
            info_bytes <= '0;
         end else begin
            out_vld <= in_vld;
            if (in_vld) begin
               need_info  <= need.l;
               byte_cnt   <= cnt_c;
               info_bytes <= bytes_c;
            end
         end
      end

      // R2: a hypervisor change always costs at least the extension byte
      a_r2_hyp_needs_ext: assert property (@(posedge clk) disable iff (!rst_n)
         in_vld && (hypmode_in != last_hypmode) |=> byte_cnt >= 2'd2);
      // R9: instruction-only mode never ends on a resume byte
      a_r9_no_resume_byte: assert property (@(posedge clk) disable iff (!rst_n)
         in_vld && instr_only |=> (byte_cnt != 2'd3) && !(byte_cnt == 2'd2 && info_bytes[14]));
      // R5: leading continuation bit tracks the count
      a_r5_lead_cont: assert property (@(posedge clk) disable iff (!rst_n)
         out_vld && (byte_cnt != 2'd0) |-> info_bytes[7] == (byte_cnt > 2'd1));
      // R7: full packet is L, X, P with the kind bits in place
      a_r7_three_order: assert property (@(posedge clk) disable iff (!rst_n)
         out_vld && byte_cnt == 2'd3 |-> info_bytes[15] && !info_bytes[14] && !info_bytes[23] && info_bytes[22]);
      // R4: flag agrees with count
      a_r4_flag_cnt: assert property (@(posedge clk) disable iff (!rst_n)
         out_vld |-> need_info == (byte_cnt != 2'd0));
      // R10: one-cycle latency and hold
      a_r10_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
         in_vld |=> out_vld);
      a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !in_vld |=> !out_vld && $stable(byte_cnt) && $stable(info_bytes));
   end else begin : g_comb
      assign out_vld    = in_vld;
      assign need_info  = need.l;
      assign byte_cnt   = cnt_c;
      assign info_bytes = bytes_c;
   end
endmodule

// File: tb/tb_xinfo_gen.sv
`timescale 1ns/1ps
module tb_xinfo_gen;
   logic clk = 1'b0, rst_n = 1'b0;
   logic in_vld = 0, instr_only = 0, cancel_in = 0;
   logic [8:0] exc_num = '0;
   logic [3:0] resume_code = '0;
   logic nonsec_in = 0, alt_iset_in = 0, hypmode_in = 0;
   logic last_nonsec = 0, last_alt_iset = 0, last_hypmode = 0;
   logic out_vld, need_info;
   logic [1:0] byte_cnt;
   logic [23:0] info_bytes;
   int n_chk = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   xinfo_gen dut (.*);

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic run_vec(input bit mode, input logic [2:0] cur, input logic [2:0] last,
                          input bit can, input logic [3:0] res, input logic [8:0] ex);
      bit e_can, n0, n1, n2, g_x, g_p;
      logic [3:0] e_res;
      logic [7:0] b0, b1, b2;
      logic [23:0] e_bytes;
      int e_cnt;
      logic [1:0] h_cnt;
      logic [23:0] h_bytes;
      e_can = mode ? (can | (res != 0)) : can;
      e_res = mode ? 4'd0 : res;
      n2 = (e_res != 0);
      n1 = (ex[8:4] != 0) || (cur[1] != last[1]);
      n0 = (cur != last) || (ex != 0) || n2 || e_can;
      b0 = {n1 | n2, cur[2], e_can, ex[3:0], cur[0]};
      b1 = {n2, 1'b0, cur[1], ex[8:4]};
      b2 = {4'b0100, e_res};
      e_cnt = int'(n0) + int'(n1) + int'(n2);
      e_bytes = {(n1 && n2) ? b2 : 8'h00, n1 ? b1 : (n2 ? b2 : 8'h00), n0 ? b0 : 8'h00};
      @(negedge clk);
      in_vld = 1; instr_only = mode; cancel_in = can; resume_code = res; exc_num = ex;
      {alt_iset_in, hypmode_in, nonsec_in} = cur;
      {last_alt_iset, last_hypmode, last_nonsec} = last;
      @(negedge clk);
      in_vld = 0;
      g_x = (byte_cnt >= 2) && !info_bytes[14];
      g_p = (byte_cnt == 3) || (byte_cnt == 2 && info_bytes[14]);
      chk(out_vld == 1'b1, "R10", "out_vld after input", int'(out_vld), 1);
      chk((byte_cnt != 0) == n0, "R1", "leading byte present", int'(byte_cnt != 0), int'(n0));
      chk(g_x == n1, "R2", "extension byte present", int'(g_x), int'(n1));
      chk(g_p == n2, "R3", "resume byte present", int'(g_p), int'(n2));
      chk(int'(byte_cnt) == e_cnt, "R4", "byte_cnt", int'(byte_cnt), e_cnt);
      chk(need_info == (e_cnt != 0), "R4", "need_info", int'(need_info), int'(e_cnt != 0));
      chk(info_bytes[7:0] == e_bytes[7:0], "R5", "leading byte", int'(info_bytes[7:0]), int'(e_bytes[7:0]));
      if (n1) chk(info_bytes[15:8] == b1, "R6", "extension byte", int'(info_bytes[15:8]), int'(b1));
      if (n2) chk(info_bytes[8*(e_cnt-1) +: 8] == b2, "R7", "resume byte",
                  int'(info_bytes[8*(e_cnt-1) +: 8]), int'(b2));
      chk(info_bytes == e_bytes, "R8", "compacted bytes", int'(info_bytes), int'(e_bytes));
      if (mode) chk(!g_p, "R9", "no resume byte in instr-only", int'(g_p), 0);
      h_cnt = byte_cnt; h_bytes = info_bytes;
      exc_num = ~ex; resume_code = ~res; cancel_in = ~can; hypmode_in = ~cur[1];
      @(negedge clk);
      chk(out_vld == 1'b0, "R10", "out_vld idle", int'(out_vld), 0);
      chk(byte_cnt == h_cnt && info_bytes == h_bytes, "R10", "hold while idle",
          int'(info_bytes), int'(h_bytes));
   endtask

   initial begin
      logic [8:0] exs [7];
      logic [3:0] ress [4];
      int it = 0;
      exs = '{9'h000, 9'h001, 9'h009, 9'h00F, 9'h010, 9'h0A5, 9'h1FF};
      ress = '{4'h0, 4'h1, 4'h9, 4'hF};
      repeat (3) @(negedge clk);
      chk(out_vld == 0 && need_info == 0 && byte_cnt == 0 && info_bytes == 0,
          "R11", "reset outputs", int'(info_bytes), 0);
      rst_n = 1'b1;
      for (int m = 0; m < 2; m++)
         for (int c = 0; c < 8; c++)
            for (int k = 0; k < 2; k++)
               for (int r = 0; r < 4; r++)
                  for (int e = 0; e < 7; e++) begin
                     logic [2:0] lst;
                     lst = 3'(it);
                     run_vec(m[0], lst ^ 3'(c), lst, k[0], ress[r], exs[e]);
                     it++;
                  end
      for (int e = 0; e < 512; e++) run_vec(1'b0, 3'b101, 3'b101, 1'b0, 4'h0, 9'(e));
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule